// File: doc/BRIEF.md
# Transmit Gearbox for Parallel Serial Lanes

This block sits between a slow base clock, on which a wide trigger word arrives once per cycle, and a frame clock that runs at an exact integer multiple of it, phase locked. On each base edge it captures the word, then it emits that word as a fixed run of fragments, one fragment per frame cycle. Each fragment is laid across a set of data lanes. Every lane gets a narrow parallel word that a serializer downstream shifts out. One extra lane carries a constant pattern from which the far end rebuilds the bit clock. Markers such as the orbit flag are ordinary bits of the word and get no special handling.

The fragment order restarts from zero on every base cycle and there is no elastic buffer, so the first fragment leaves one frame cycle after the capture edge. A `VARIANT` parameter picks the geometry. Variant 0 (the default) uses a ratio of 5, 6 bits per lane and a 330-bit word. Variant 1 uses a ratio of 7, 4 bits per lane and a 308-bit word. Both variants have 11 data lanes. A training input, captured together with the word, replaces the data with an alignment pattern. The receiver uses that pattern to find fragment and word boundaries.

Top module: `gbx_tx_gearbox`

## Requirements
- R1: For fragment k, data lane n carries word bits starting at LSB index k*LANES*BPL + n*BPL, BPL bits wide. Lane n occupies `lane_data_o[n*BPL +: BPL]`, so fragment 0 holds the least significant bits of the word.
- R2: The fragments of one word leave in order 0, 1, ..., RATIO-1, one per frame cycle. The next word's fragment 0 follows directly after fragment RATIO-1, with no gap.
- R3: `frag_idx_o` gives the index of the fragment currently on the lanes. `word_start_o` is high exactly while fragment 0 is on the lanes.
- R4: Fragment 0 of a word appears on the outputs after the first frame edge that follows the base edge that captured the word. This is one frame cycle of latency.
- R5: After the first word following reset, the clock lane holds a fixed pattern in which even bit positions are 1 and odd bit positions are 0. For BPL=6 this is 6'b010101.
- R6: When `train_in` is high at the capture edge, that word's data is replaced. In fragment 0 every lane carries the marker, which has ones in its low BPL/2 bits and zeros above (6'b000111 for BPL=6). In every other fragment each lane carries the complement of the marker (6'b111000). Words captured with `train_in` low carry data again.
- R7: During reset, and afterwards until the first base edge, all lane outputs, `frag_idx_o` and `word_start_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_clk | input | 1 | Base clock, one word per rising edge |
| frame_clk | input | 1 | Frame clock, RATIO times base_clk, phase locked |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| word_in | input | WORD_W | Word to transmit, captured on base_clk |
| train_in | input | 1 | Send the alignment pattern instead of the word |
| lane_data_o | output | LANES*BPL | Parallel words for the data lane serializers |
| clk_lane_o | output | BPL | Parallel word for the forwarded clock lane |
| frag_idx_o | output | IDXW | Index of the fragment on the lanes |
| word_start_o | output | 1 | High while fragment 0 is on the lanes |

## Verification
The assertions assume that both clocks are phase locked at the exact ratio, with each base rising edge falling on a frame rising edge. They also assume that reset is released away from any edge. Under these conditions fragment RATIO-1 is always followed by a new start, and that is exactly what the sequencing properties check. The bench derives both clocks from one time base with periods of 4 ns and 20 ns, so their rising edges line up. It releases reset between edges and changes `word_in` and `train_in` only on base falling edges, which keeps every capture clean.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  // geometry per variant: 0 -> ratio 5 / 6 bits, 1 -> ratio 7 / 4 bits
  function automatic int ratio_of(int variant);
    return (variant == 1) ? 7 : 5;
  endfunction

  function automatic int bpl_of(int variant);
    return (variant == 1) ? 4 : 6;
  endfunction

  // LSB position of lane n within fragment k
  function automatic int frag_lsb(int k, int n, int bpl, int lanes);
    return (k * lanes + n) * bpl;
  endfunction

  // alignment marker: low half ones; complemented when not the first fragment
  function automatic logic [15:0] marker_lane(int bpl, bit first);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < bpl; i++) m[i] = ((i < bpl / 2) == first);
    return m;
  endfunction

  // forwarded clock: ones on even bit positions
  function automatic logic [15:0] clk_pattern(int bpl);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < bpl; i++) m[i] = (i % 2 == 0);
    return m;
  endfunction
endpackage

// File: rtl/gbx_capture.sv
module gbx_capture #(
  parameter int WORD_W = 330
) (
  input  logic              base_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              train_in,
  output logic [WORD_W-1:0] word_q,
  output logic              train_q,
  output logic              tgl_q
);
  always_ff @(posedge base_clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      train_q <= 1'b0;
      tgl_q   <= 1'b0;
    end else begin
      word_q  <= word_in;
      train_q <= train_in;
      tgl_q   <= ~tgl_q;
    end
  end
endmodule

// File: rtl/gbx_phase.sv
module gbx_phase #(
  parameter int RATIO = 5,
  parameter int IDXW  = 3
) (
  input  logic            frame_clk,
  input  logic            rst_n,
  input  logic            base_tgl,
  output logic            start_o,
  output logic            emit_o,
  output logic [IDXW-1:0] sel_o,
  output logic            running_o
);
  localparam logic [IDXW-1:0] RATIO_W = IDXW'(RATIO);

  logic            seen_q;
  logic [IDXW-1:0] nxt_q;

  assign start_o = base_tgl ^ seen_q;
  assign emit_o  = start_o | (running_o & (nxt_q < RATIO_W));
  assign sel_o   = start_o ? '0 : nxt_q;

  always_ff @(posedge frame_clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      nxt_q     <= '0;
      running_o <= 1'b0;
    end else begin
      seen_q <= base_tgl;
      if (start_o) begin
        nxt_q     <= IDXW'(1);
        running_o <= 1'b1;
      end else if (emit_o) begin
        nxt_q <= nxt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gbx_lane_map.sv
module gbx_lane_map #(
  parameter int LANES = 11,
  parameter int BPL   = 6,
  parameter int RATIO = 5,
  parameter int IDXW  = 3,
  localparam int WORD_W = LANES * BPL * RATIO
) (
  input  logic [WORD_W-1:0]    word_i,
  input  logic                 train_i,
  input  logic [IDXW-1:0]      sel_i,
  output logic [LANES*BPL-1:0] lanes_o
);
  localparam logic [BPL-1:0] MARK_FIRST = BPL'(gbx_pkg::marker_lane(BPL, 1'b1));
  localparam logic [BPL-1:0] MARK_REST  = BPL'(gbx_pkg::marker_lane(BPL, 1'b0));

  logic [BPL-1:0] pattern;
  assign pattern = (sel_i == '0) ? MARK_FIRST : MARK_REST;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [BPL-1:0] dat;
    assign dat = word_i[gbx_pkg::frag_lsb(int'(sel_i), n, BPL, LANES) +: BPL];
    assign lanes_o[n*BPL +: BPL] = train_i ? pattern : dat;
  end
endmodule

// File: rtl/gbx_tx_gearbox.sv
module gbx_tx_gearbox #(
  parameter int VARIANT = 0,
  parameter int LANES   = 11,
  localparam int RATIO  = gbx_pkg::ratio_of(VARIANT),
  localparam int BPL    = gbx_pkg::bpl_of(VARIANT),
  localparam int WORD_W = RATIO * LANES * BPL,
  localparam int IDXW   = $clog2(RATIO + 1)
) (
  input  logic                 base_clk,
  input  logic                 frame_clk,
  input  logic                 rst_n,
  input  logic [WORD_W-1:0]    word_in,
  input  logic                 train_in,
  output logic [LANES*BPL-1:0] lane_data_o,
  output logic [BPL-1:0]       clk_lane_o,
  output logic [IDXW-1:0]      frag_idx_o,
  output logic                 word_start_o
);
  localparam logic [BPL-1:0] CLK_PAT = BPL'(gbx_pkg::clk_pattern(BPL));

  logic [WORD_W-1:0]    word_q;
  logic                 train_q;
  logic                 base_tgl;
  logic                 start_w;
  logic                 emit_w;
  logic [IDXW-1:0]      sel_w;
  logic                 run_w;
  logic [WORD_W-1:0]    wcopy_q;
  logic                 tcopy_q;
  logic [WORD_W-1:0]    src_word;
  logic                 src_train;
  logic [LANES*BPL-1:0] lanes_w;

  gbx_capture #(.WORD_W(WORD_W)) u_cap (
    .base_clk (base_clk),
    .rst_n    (rst_n),
    .word_in  (word_in),
    .train_in (train_in),
    .word_q   (word_q),
    .train_q  (train_q),
    .tgl_q    (base_tgl)
  );

  gbx_phase #(.RATIO(RATIO), .IDXW(IDXW)) u_phase (
    .frame_clk (frame_clk),
    .rst_n     (rst_n),
    .base_tgl  (base_tgl),
    .start_o   (start_w),
    .emit_o    (emit_w),
    .sel_o     (sel_w),
    .running_o (run_w)
  );

  // on the start cycle read the base register directly, later the frame copy
  assign src_word  = start_w ? word_q  : wcopy_q;
  assign src_train = start_w ? train_q : tcopy_q;

  gbx_lane_map #(.LANES(LANES), .BPL(BPL), .RATIO(RATIO), .IDXW(IDXW)) u_map (
    .word_i  (src_word),
    .train_i (src_train),
    .sel_i   (sel_w),
    .lanes_o (lanes_w)
  );

  always_ff @(posedge frame_clk or negedge rst_n) begin
    if (!rst_n) begin
      wcopy_q      <= '0;
      tcopy_q      <= 1'b0;
      lane_data_o  <= '0;
      clk_lane_o   <= '0;
      frag_idx_o   <= '0;
      word_start_o <= 1'b0;
    end else begin
      word_start_o <= start_w;
      if (start_w) begin
        wcopy_q    <= word_q;
        tcopy_q    <= train_q;
        clk_lane_o <= CLK_PAT;
      end
      if (emit_w) begin
        lane_data_o <= lanes_w;
        frag_idx_o  <= sel_w;
      end
    end
  end
endmodule

// File: rtl/gbx_tx_gearbox_chk.sv
module gbx_tx_gearbox_chk #(
  parameter int RATIO = 5,
  parameter int BPL   = 6,
  parameter int IDXW  = 3
) (
  input logic            frame_clk,
  input logic            rst_n,
  input logic            start,
  input logic            running,
  input logic [IDXW-1:0] frag_idx,
  input logic            word_start,
  input logic [BPL-1:0]  clk_lane
);
  localparam logic [IDXW-1:0] LAST = IDXW'(RATIO - 1);

  // R2: inside a word the index steps by one each frame cycle
  assert_idx_step_R2: assert property (@(posedge frame_clk) disable iff (!rst_n)
    (running && frag_idx < LAST) |=> (frag_idx == $past(frag_idx) + 1'b1));

  // R2: the last fragment is followed at once by a new word
  assert_no_gap_R2: assert property (@(posedge frame_clk) disable iff (!rst_n)
    (running && frag_idx == LAST) |=> word_start);

  // R3: the start flag only accompanies fragment 0
  assert_start_is_first_R3: assert property (@(posedge frame_clk) disable iff (!rst_n)
    word_start |-> (frag_idx == '0));

  // R4: a detected base edge puts fragment 0 out on the next frame edge
  assert_latency_R4: assert property (@(posedge frame_clk) disable iff (!rst_n)
    start |=> (word_start && frag_idx == '0));

  // R5: once running, the clock lane does not change
  assert_clk_lane_R5: assert property (@(posedge frame_clk) disable iff (!rst_n)
    running |=> $stable(clk_lane));
endmodule

bind gbx_tx_gearbox gbx_tx_gearbox_chk #(.RATIO(RATIO), .BPL(BPL), .IDXW(IDXW)) u_chk (
  .frame_clk  (frame_clk),
  .rst_n      (rst_n),
  .start      (start_w),
  .running    (run_w),
  .frag_idx   (frag_idx_o),
  .word_start (word_start_o),
  .clk_lane   (clk_lane_o)
);

// File: tb/gbx_tx_gearbox_test.sv
module gbx_tx_gearbox_test;
  localparam int NL = 11;
  localparam int NB = 6;
  localparam int NF = 5;
  localparam int FW = NL * NB;
  localparam int WW = FW * NF;

  logic          base_clk = 1'b0;
  logic          frame_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WW-1:0] word_in = '0;
  logic          train_in = 1'b0;
  logic [FW-1:0] lane_data_o;
  logic [NB-1:0] clk_lane_o;
  logic [2:0]    frag_idx_o;
  logic          word_start_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 frame_clk = ~frame_clk;   // 250 MHz
  always #10 base_clk = ~base_clk;    // ratio 5, edges aligned

  gbx_tx_gearbox uut (
    .base_clk     (base_clk),
    .frame_clk    (frame_clk),
    .rst_n        (rst_n),
    .word_in      (word_in),
    .train_in     (train_in),
    .lane_data_o  (lane_data_o),
    .clk_lane_o   (clk_lane_o),
    .frag_idx_o   (frag_idx_o),
    .word_start_o (word_start_o)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] clk_exp();
    logic [NB-1:0] c;
    for (int b = 0; b < NB; b++) c[b] = ~b[0];
    return c;
  endfunction

  function automatic logic [NB-1:0] mark_exp();
    return NB'((1 << (NB / 2)) - 1);
  endfunction

  // word generators: 0 mixed pattern, 1 single bit, 2 alternating full words
  function automatic logic [WW-1:0] gen(int kind, int i);
    logic [WW-1:0] w;
    for (int b = 0; b < WW; b++) begin
      case (kind)
        0: w[b] = (((b * 7 + i * 13) % 5) == 0) ^ i[0];
        1: w[b] = (b == ((i * 37) % WW)) || (b == WW - 1 && i[0]);
        default: w[b] = i[0];
      endcase
    end
    return w;
  endfunction

  function automatic logic [FW-1:0] exp_frag(logic [WW-1:0] w, bit tr, int k);
    logic [FW-1:0] e;
    for (int n = 0; n < NL; n++)
      for (int b = 0; b < NB; b++)
        e[n*NB + b] = tr ? ((k == 0) ? mark_exp()[b] : ~mark_exp()[b])
                         : w[k*FW + n*NB + b];
    return e;
  endfunction

  task automatic check_reset();
    check("R7 lanes in reset", 128'(lane_data_o), 128'(0));
    check("R7 idx/start in reset", 128'({frag_idx_o, word_start_o}), 128'(0));
    #3 rst_n = 1'b1;
    @(negedge frame_clk);
    check("R7 lanes before first word", 128'(lane_data_o), 128'(0));
    check("R7 clock lane before first word", 128'(clk_lane_o), 128'(0));
  endtask

  // R1 R2 R3 R4 R5 R6: stream n words back to back, training for the first ntr
  task automatic run_stream(int kind, int n, int ntr);
    @(negedge base_clk);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          word_in  = gen(kind, i);
          train_in = (i < ntr);
          @(negedge base_clk);
        end
      end
      begin
        @(posedge base_clk);
        @(negedge frame_clk);
        check("R4 fragment 0 not out before first frame edge", 128'(word_start_o), 128'(0));
        for (int i = 0; i < n; i++) begin
          for (int k = 0; k < NF; k++) begin
            @(negedge frame_clk);
            check((i < ntr) ? "R6 training lanes" : "R1 lane mapping",
                  128'(lane_data_o), 128'(exp_frag(gen(kind, i), i < ntr, k)));
            check("R2 R3 index and start", 128'({frag_idx_o, word_start_o}),
                  128'({3'(k), k == 0}));
            check("R5 clock lane", 128'(clk_lane_o), 128'(clk_exp()));
          end
        end
      end
    join
  endtask

  initial begin
    #1;
    check_reset();
    run_stream(0, 6, 0);
    run_stream(1, 12, 0);
    run_stream(2, 4, 0);
    run_stream(0, 6, 3);
    run_stream(1, 3, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule